// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits on an 8-bit register write bus and decides when a flash erase may begin. Software first makes a preparatory write (a page number for a page erase, or any byte to the mass-erase enable location for a full erase). It then writes a key byte to the command location. The block launches an erase only when three things hold: the key is one of the two recognised values, the matching preparation is armed, and the flash array controller is idle. A mass erase also needs the debug-enable input high.

An accepted command produces a single-cycle start pulse toward the flash array controller. The pulse comes with an erase-type flag and a 7-bit page number. Accepting a command consumes its preparation, so every erase needs a fresh preparatory write. A sticky status bit records whether the most recent key write was refused. Software can read the page register and a status register through a registered read port.

Top module: `flash_erase_seq`

## Requirements
- R1: With the page preparation armed and `flash_busy` low, writing 0x55 to address 0x94 makes `erase_start` high for exactly the one cycle after the write edge, with `erase_mass` = 0 and `erase_page` equal to bits 6:0 of the page register.
- R2: With the mass preparation armed, `dbg_en` high and `flash_busy` low, writing 0xAA to address 0x94 makes `erase_start` high for the one cycle after the write edge, with `erase_mass` = 1.
- R3: A write to address 0x94 of any byte other than 0x55 or 0xAA starts nothing and leaves the armed flags and the reject bit unchanged.
- R4: A write of any byte to address 0xB7 stores that byte and arms the page preparation. A 0x55 key with the page preparation not armed is refused. An accepted page erase disarms it.
- R5: A write of any byte to address 0xB2 arms the mass preparation. A 0xAA key is refused when the mass preparation is not armed or `dbg_en` is low. An accepted mass erase disarms it. A refused key disarms nothing.
- R6: A key write while `flash_busy` is high is refused. It starts nothing and clears no armed flag.
- R7: Reads return data on `rd_data` one cycle after `rd_addr` is presented. Address 0xB7 returns the full stored byte. Status address 0xB4 returns bit0 = reject, bit1 = page armed and bit2 = mass armed, with the other bits 0. Address 0x94 and unmapped addresses return 0x00.
- R8: The reject bit is set by every refused key write and stays set until the next accepted command clears it.
- R9: Synchronous active-high `rst` clears the page register to 0x00, both armed flags, the reject bit, `rd_data` and `erase_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Registered read data |
| dbg_en | input | 1 | Debug port enabled, required for mass erase |
| flash_busy | input | 1 | Flash array controller is erasing |
| erase_start | output | 1 | One-cycle erase launch pulse |
| erase_mass | output | 1 | Erase type: 0 page, 1 mass |
| erase_page | output | 7 | Page number to erase |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 7-bit page number and the 0x94/0xB7/0xB2/0xB4 address map. With these defaults a page byte with bit 7 set shows that only the low seven bits reach `erase_page` while read-back keeps the whole byte. The status register exposes every armed flag and the reject bit. This lets each refused, ignored or busy-blocked command be confirmed at the ports without looking inside the design.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic {
    KIND_PAGE = 1'b0,
    KIND_MASS = 1'b1
  } erase_kind_e;

  typedef struct packed {
    logic        go;
    erase_kind_e kind;
  } launch_t;
endpackage

// File: rtl/fes_prep_regs.sv
module fes_prep_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] PAGE_ADDR = 8'hB7,
  parameter logic [AW-1:0] MEEN_ADDR = 8'hB2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          accept_page,
  input  logic          accept_mass,
  output logic [DW-1:0] page_q,
  output logic          page_armed,
  output logic          mass_armed
);
  logic page_wr, meen_wr;
  assign page_wr = wr_en && (wr_addr == PAGE_ADDR);
  assign meen_wr = wr_en && (wr_addr == MEEN_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q     <= '0;
      page_armed <= 1'b0;
      mass_armed <= 1'b0;
    end else begin
      if (page_wr) begin
        page_q     <= wr_data;
        page_armed <= 1'b1;
      end else if (accept_page) begin
        page_armed <= 1'b0;
      end
      if (meen_wr)
        mass_armed <= 1'b1;
      else if (accept_mass)
        mass_armed <= 1'b0;
    end
  end

  AST_PAGE_DISARM: assert property (@(posedge clk) disable iff (rst)
    accept_page |=> !page_armed); // R4
  AST_MASS_DISARM: assert property (@(posedge clk) disable iff (rst)
    accept_mass |=> !mass_armed); // R5
endmodule

// File: rtl/fes_cmd_check.sv
module fes_cmd_check
  import fes_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] CMD_ADDR = 8'h94,
  parameter logic [DW-1:0] KEY_PAGE = 8'h55,
  parameter logic [DW-1:0] KEY_MASS = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          page_armed,
  input  logic          mass_armed,
  input  logic          dbg_en,
  input  logic          flash_busy,
  output logic          accept_page,
  output logic          accept_mass,
  output launch_t       launch,
  output logic          reject_q
);
  logic cmd_wr, is_page_key, is_mass_key, key_wr, refused;

  assign cmd_wr      = wr_en && (wr_addr == CMD_ADDR);
  assign is_page_key = cmd_wr && (wr_data == KEY_PAGE);
  assign is_mass_key = cmd_wr && (wr_data == KEY_MASS);
  assign key_wr      = is_page_key || is_mass_key;

  assign accept_page = is_page_key && page_armed && !flash_busy;
  assign accept_mass = is_mass_key && mass_armed && dbg_en && !flash_busy;
  assign refused     = key_wr && !(accept_page || accept_mass);

  always_comb begin
    launch.go   = accept_page || accept_mass;
    launch.kind = accept_mass ? KIND_MASS : KIND_PAGE;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reject_q <= 1'b0;
    else if (refused)
      reject_q <= 1'b1;
    else if (launch.go)
      reject_q <= 1'b0;
  end

  AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (reject_q && !launch.go) |=> reject_q); // R8
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (key_wr && flash_busy) |=> reject_q); // R6
endmodule

// File: rtl/fes_launch.sv
module fes_launch
  import fes_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  launch_t           launch,
  input  logic [DW-1:0]     page_q,
  input  logic              dbg_en,
  input  logic              flash_busy,
  output logic              erase_start,
  output logic              erase_mass,
  output logic [PAGE_W-1:0] erase_page
);
  always_ff @(posedge clk) begin
    if (rst) begin
      erase_start <= 1'b0;
      erase_mass  <= 1'b0;
      erase_page  <= '0;
    end else begin
      erase_start <= launch.go;
      if (launch.go) begin
        erase_mass <= (launch.kind == KIND_MASS);
        erase_page <= page_q[PAGE_W-1:0];
      end
    end
  end

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    flash_busy |=> !erase_start); // R6
  AST_MASS_DBG: assert property (@(posedge clk) disable iff (rst)
    !dbg_en |=> !(erase_start && erase_mass)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !erase_start); // R9
endmodule

// File: rtl/fes_readback.sv
module fes_readback #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] PAGE_ADDR = 8'hB7,
  parameter logic [AW-1:0] STAT_ADDR = 8'hB4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] page_q,
  input  logic          reject_q,
  input  logic          page_armed,
  input  logic          mass_armed,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] stat_word, rd_next;

  always_comb begin
    stat_word    = '0;
    stat_word[0] = reject_q;
    stat_word[1] = page_armed;
    stat_word[2] = mass_armed;
  end

  always_comb begin
    if (rd_addr == PAGE_ADDR)      rd_next = page_q;
    else if (rd_addr == STAT_ADDR) rd_next = stat_word;
    else                           rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == STAT_ADDR) |=> (rd_data[DW-1:3] == '0)); // R7
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter int PAGE_W = 7,
  parameter logic [AW-1:0] CMD_ADDR  = 8'h94,
  parameter logic [AW-1:0] PAGE_ADDR = 8'hB7,
  parameter logic [AW-1:0] MEEN_ADDR = 8'hB2,
  parameter logic [AW-1:0] STAT_ADDR = 8'hB4,
  parameter logic [DW-1:0] KEY_PAGE  = 8'h55,
  parameter logic [DW-1:0] KEY_MASS  = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              dbg_en,
  input  logic              flash_busy,
  output logic              erase_start,
  output logic              erase_mass,
  output logic [PAGE_W-1:0] erase_page
);
  logic [DW-1:0] page_q;
  logic          page_armed, mass_armed, accept_page, accept_mass, reject_q;
  launch_t       launch;

  fes_prep_regs #(.AW(AW), .DW(DW), .PAGE_ADDR(PAGE_ADDR), .MEEN_ADDR(MEEN_ADDR)) u_prep (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .accept_page(accept_page), .accept_mass(accept_mass),
    .page_q(page_q), .page_armed(page_armed), .mass_armed(mass_armed));

  fes_cmd_check #(.AW(AW), .DW(DW), .CMD_ADDR(CMD_ADDR), .KEY_PAGE(KEY_PAGE),
                  .KEY_MASS(KEY_MASS)) u_check (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .page_armed(page_armed), .mass_armed(mass_armed), .dbg_en(dbg_en),
    .flash_busy(flash_busy), .accept_page(accept_page), .accept_mass(accept_mass),
    .launch(launch), .reject_q(reject_q));

  fes_launch #(.DW(DW), .PAGE_W(PAGE_W)) u_launch (
    .clk(clk), .rst(rst), .launch(launch), .page_q(page_q), .dbg_en(dbg_en),
    .flash_busy(flash_busy), .erase_start(erase_start), .erase_mass(erase_mass),
    .erase_page(erase_page));

  fes_readback #(.AW(AW), .DW(DW), .PAGE_ADDR(PAGE_ADDR), .STAT_ADDR(STAT_ADDR)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .page_q(page_q), .reject_q(reject_q),
    .page_armed(page_armed), .mass_armed(mass_armed), .rd_data(rd_data));

  AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == CMD_ADDR) |=> !erase_start); // R3
endmodule

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       dbg_en = 1'b0, flash_busy = 1'b0;
  logic       erase_start, erase_mass;
  logic [6:0] erase_page;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_erase_seq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dbg_en(dbg_en), .flash_busy(flash_busy),
    .erase_start(erase_start), .erase_mass(erase_mass), .erase_page(erase_page));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Returns at the falling edge after the write edge, where a start pulse is visible.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R9 start", erase_start, 0);
    rd(8'hB7, v); check("R9 page reg", v, 0);
    rd(8'hB4, v); check("R9 status", v, 0);
    rd(8'h94, v); check("R7 cmd reads zero", v, 0);
  endtask

  task automatic t_page_ok();
    logic [7:0] v;
    wr(8'hB7, 8'h85);
    rd(8'hB7, v); check("R7 page readback", v, 8'h85);
    rd(8'hB4, v); check("R4 page armed", v, 8'h02);
    wr(8'h94, 8'h55);
    check("R1 start", erase_start, 1);
    check("R1 type page", erase_mass, 0);
    check("R1 page low bits", erase_page, 7'h05);
    @(negedge clk); check("R1 single pulse", erase_start, 0);
    rd(8'hB4, v); check("R4 disarmed after accept", v, 8'h00);
  endtask

  task automatic t_page_noarm();
    logic [7:0] v;
    wr(8'h94, 8'h55);
    check("R4 refused no start", erase_start, 0);
    rd(8'hB4, v); check("R8 reject set", v, 8'h01);
    wr(8'hB7, 8'h12);
    wr(8'h94, 8'h55);
    check("R4 rearmed start", erase_start, 1);
    check("R1 page 0x12", erase_page, 7'h12);
    rd(8'hB4, v); check("R8 reject cleared", v, 8'h00);
  endtask

  task automatic t_other_values();
    logic [7:0] v;
    wr(8'hB7, 8'h07);
    wr(8'h94, 8'h00); check("R3 0x00 no start", erase_start, 0);
    wr(8'h94, 8'h54); check("R3 0x54 no start", erase_start, 0);
    wr(8'h94, 8'hFF); check("R3 0xFF no start", erase_start, 0);
    rd(8'hB4, v); check("R3 flags unchanged", v, 8'h02);
    wr(8'h94, 8'h55); check("R3 arm survived", erase_start, 1);
  endtask

  task automatic t_mass();
    logic [7:0] v;
    dbg_en = 1'b0;
    wr(8'hB2, 8'h3C);
    wr(8'h94, 8'hAA);
    check("R5 no dbg no start", erase_start, 0);
    rd(8'hB4, v); check("R5 arm kept, reject", v, 8'h05);
    dbg_en = 1'b1;
    wr(8'h94, 8'hAA);
    check("R2 mass start", erase_start, 1);
    check("R2 type mass", erase_mass, 1);
    rd(8'hB4, v); check("R5 disarmed, R8 cleared", v, 8'h00);
    wr(8'h94, 8'hAA);
    check("R5 unarmed refused", erase_start, 0);
    dbg_en = 1'b0;
  endtask

  task automatic t_busy();
    logic [7:0] v;
    wr(8'hB7, 8'h21);
    flash_busy = 1'b1;
    wr(8'h94, 8'h55);
    check("R6 busy no start", erase_start, 0);
    rd(8'hB4, v); check("R6 arm kept, reject", v, 8'h03);
    flash_busy = 1'b0;
    wr(8'h94, 8'h55);
    check("R6 after busy start", erase_start, 1);
    check("R6 page", erase_page, 7'h21);
  endtask

  task automatic t_reset_mid();
    logic [7:0] v;
    wr(8'hB7, 8'h44);
    wr(8'hB2, 8'h01);
    wr(8'h94, 8'hAA);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 start after reset", erase_start, 0);
    rd(8'hB4, v); check("R9 status cleared", v, 8'h00);
    rd(8'hB7, v); check("R9 page cleared", v, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_page_ok();
    t_page_noarm();
    t_other_values();
    t_mass();
    t_busy();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule